// File: doc/BRIEF.md
# Per-Connection Cell Rate Policer with Frame Mode

This block checks each arriving ATM cell against the traffic contract of its connection using the generic cell rate algorithm in its virtual-scheduling form. Every connection has its own table entry: an emission increment, a tolerance, a theoretical arrival time (TAT), a policy bit that chooses between tagging and discarding, a frame-mode bit and a small frame state. For each cell presented with its connection index, loss-priority bit, end-of-frame flag and the current value of a free-running time counter, the block gives one verdict in the next cycle: pass, tag (loss priority forced to 1) or discard.

In cell mode every cell is judged on its own. In frame mode, which serves minimum-rate frame services, only the head cell of a frame is judged and the whole frame follows it. The head of a frame is the first cell after an end-of-frame cell, or the first cell after the connection is configured. A frame whose head fails is penalised to its end. In a discarding frame the end-of-frame cell is tagged and not dropped, so that the next frame boundary still reaches downstream logic.

A single write port loads a connection's contract. The same write clears that connection's counters of passed, tagged and discarded cells. A read index returns those three counters.

Top module: `gcra_policer`

## Requirements
- R1: While reset is held and in the cycle after it, `vrd_vld` is 0 and all three counters of every connection read 0.
- R2: A cell can be offered in every cycle. A cell sampled at a clock edge gives `vrd_vld` = 1 after the next edge. A cycle with no cell gives `vrd_vld` = 0.
- R3: `vrd_code` is 2'b00 for pass, 2'b01 for tag and 2'b10 for discard, and is never 2'b11. On pass, `vrd_clp` equals the incoming `cell_clp`. On tag, `vrd_clp` is 1.
- R4: A cell on a connection that has not been written since reset is discarded and leaves no state behind.
- R5: A cell at time t conforms unless TAT is ahead of t by more than the tolerance, that is, unless TAT − t > tol.
- R6: A conforming (or passed) cell sets TAT to max(t, TAT) + increment. A cell that is not passed leaves TAT unchanged.
- R7: Time and TAT are compared modulo 2^TIME_W. TAT counts as ahead when (TAT − t) mod 2^TIME_W is below half the range. This makes the test correct across a counter wrap.
- R8: In cell mode a nonconforming cell is tagged when the connection's discard bit is 0 and discarded when it is 1.
- R9: In frame mode only the head cell is tested. If the head conforms, every later cell of that frame passes and advances TAT, whether or not it would conform.
- R10: In frame mode, if the head fails, every cell of that frame gets the penalty and TAT does not move. Under the discard policy the end-of-frame cell, including a one-cell frame, is tagged instead of dropped.
- R11: Each connection has counters of passed, tagged and discarded cells. The counters saturate at all ones, are cleared by a configuration write to that connection, and are read combinationally at `stat_conn`.
- R12: A configuration write sets TAT to the current `now`, clears the frame state, and enables the connection. Connections do not affect one another's verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TIME_W | Free-running time counter |
| cell_vld | input | 1 | A cell is present this cycle |
| cell_conn | input | CONN_W | Connection index of the cell |
| cell_clp | input | 1 | Incoming cell-loss-priority bit |
| cell_eof | input | 1 | Cell is the last of its frame |
| cfg_we | input | 1 | Write the contract of `cfg_conn` |
| cfg_conn | input | CONN_W | Connection being configured |
| cfg_incr | input | TIME_W | Emission increment |
| cfg_tol | input | TIME_W | Tolerance, below half the time range |
| cfg_discard | input | 1 | 1: discard nonconforming cells, 0: tag them |
| cfg_frame | input | 1 | 1: frame mode, 0: cell mode |
| stat_conn | input | CONN_W | Connection whose counters are read |
| vrd_vld | output | 1 | Verdict valid |
| vrd_code | output | 2 | 00 pass, 01 tag, 10 discard |
| vrd_clp | output | 1 | Outgoing loss-priority bit |
| stat_pass | output | CNT_W | Passed-cell count of `stat_conn` |
| stat_tag | output | CNT_W | Tagged-cell count of `stat_conn` |
| stat_drop | output | CNT_W | Discarded-cell count of `stat_conn` |

## Verification
A wrong TAT does not show at once. It stays hidden until a later cell on the same connection arrives close enough to the contract edge, and then that cell gets the wrong verdict. For this reason the bench sweeps inter-cell gaps on both sides of the tolerance and runs long enough to wrap the time counter several times. A wrong frame state shows in the very next cell of that connection, as a pass where a penalty is due or the reverse, or as a dropped end-of-frame cell. Counter faults show when the counters are read back after each traffic phase and right after a reconfiguration.

// File: rtl/gcra_pkg.sv
package gcra_pkg;

    // Verdict encoding seen at the output port
    typedef enum logic [1:0] {
        VRD_PASS = 2'b00,
        VRD_TAG  = 2'b01,
        VRD_DROP = 2'b10
    } verdict_e;

    // Per-connection frame state
    //   FR_HEAD     : next cell opens a frame and is tested
    //   FR_BODY_OK  : inside a frame whose head conformed
    //   FR_BODY_PEN : inside a frame whose head failed
    typedef enum logic [1:0] {
        FR_HEAD     = 2'b00,
        FR_BODY_OK  = 2'b01,
        FR_BODY_PEN = 2'b10
    } frame_st_e;

endpackage

// File: rtl/gcra_conform.sv
// Virtual-scheduling conformance test with a half-range modular compare.
module gcra_conform #(
    parameter int TIME_W = 24
) (
    input  logic [TIME_W-1:0] t_arr,
    input  logic [TIME_W-1:0] tat,
    input  logic [TIME_W-1:0] incr,
    input  logic [TIME_W-1:0] tol,
    output logic              conform,
    output logic [TIME_W-1:0] tat_next
);
    logic [TIME_W-1:0] lead;
    logic              ahead;

    always_comb begin
        lead     = tat - t_arr;
        // TAT counts as ahead when the difference lies in the lower half range
        ahead    = ~lead[TIME_W-1];
        conform  = ~(ahead && (lead > tol));
        tat_next = (ahead ? tat : t_arr) + incr;
    end
endmodule

// File: rtl/gcra_frame_fsm.sv
// Next-state and verdict logic of the per-connection frame state machine.
module gcra_frame_fsm
    import gcra_pkg::*;
(
    input  frame_st_e cur_st,
    input  logic      frame_en,
    input  logic      discard_pol,
    input  logic      eof,
    input  logic      conform,
    output frame_st_e nxt_st,
    output verdict_e  verdict,
    output logic      advance
);
    verdict_e penalty;

    // State transitions
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            FR_HEAD: begin
                if (frame_en && !eof)
                    nxt_st = conform ? FR_BODY_OK : FR_BODY_PEN;
            end
            FR_BODY_OK: begin
                if (eof) nxt_st = FR_HEAD;
            end
            FR_BODY_PEN: begin
                if (eof) nxt_st = FR_HEAD;
            end
            default: nxt_st = FR_HEAD;
        endcase
        if (!frame_en) nxt_st = FR_HEAD;
    end

    // Verdict and TAT-advance outputs
    always_comb begin
        // an end-of-frame cell in frame mode is never dropped
        penalty = (discard_pol && !(frame_en && eof)) ? VRD_DROP : VRD_TAG;
        verdict = penalty;
        advance = 1'b0;
        unique case (cur_st)
            FR_HEAD: begin
                if (conform) begin
                    verdict = VRD_PASS;
                    advance = 1'b1;
                end
            end
            FR_BODY_OK: begin
                verdict = VRD_PASS;
                advance = 1'b1;
            end
            FR_BODY_PEN: begin
                verdict = penalty;
            end
            default: verdict = penalty;
        endcase
    end
endmodule

// File: rtl/gcra_stats.sv
// Per-connection saturating counters, one bank per verdict kind.
module gcra_stats
    import gcra_pkg::*;
#(
    parameter int CONN_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [CONN_W-1:0] inc_conn,
    input  verdict_e          inc_kind,
    input  logic              clr,
    input  logic [CONN_W-1:0] clr_conn,
    input  logic [CONN_W-1:0] rd_conn,
    output logic [CNT_W-1:0]  rd_pass,
    output logic [CNT_W-1:0]  rd_tag,
    output logic [CNT_W-1:0]  rd_drop
);
    localparam int NCONN  = 1 << CONN_W;
    localparam int NKINDS = 3;

    logic [CNT_W-1:0] rd_cnt [NKINDS];

    for (genvar k = 0; k < NKINDS; k++) begin : g_bank
        logic [CNT_W-1:0] mem [NCONN];
        logic             hit;

        assign hit       = inc && (inc_kind == verdict_e'(k));
        assign rd_cnt[k] = mem[rd_conn];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NCONN; i++) mem[i] <= '0;
            end else begin
                if (hit && !(clr && clr_conn == inc_conn) && (mem[inc_conn] != '1))
                    mem[inc_conn] <= mem[inc_conn] + 1'b1;
                if (clr)
                    mem[clr_conn] <= '0;
            end
        end
    end

    assign rd_pass = rd_cnt[0];
    assign rd_tag  = rd_cnt[1];
    assign rd_drop = rd_cnt[2];
endmodule

// File: rtl/gcra_policer.sv
// Top: contract table, conformance, frame FSM, counters and verdict register.
module gcra_policer
    import gcra_pkg::*;
#(
    parameter int CONN_W = 10,
    parameter int TIME_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              cell_vld,
    input  logic [CONN_W-1:0] cell_conn,
    input  logic              cell_clp,
    input  logic              cell_eof,
    input  logic              cfg_we,
    input  logic [CONN_W-1:0] cfg_conn,
    input  logic [TIME_W-1:0] cfg_incr,
    input  logic [TIME_W-1:0] cfg_tol,
    input  logic              cfg_discard,
    input  logic              cfg_frame,
    input  logic [CONN_W-1:0] stat_conn,
    output logic              vrd_vld,
    output logic [1:0]        vrd_code,
    output logic              vrd_clp,
    output logic [CNT_W-1:0]  stat_pass,
    output logic [CNT_W-1:0]  stat_tag,
    output logic [CNT_W-1:0]  stat_drop
);
    localparam int NCONN = 1 << CONN_W;

    typedef struct packed {
        logic              en;
        logic              disc;
        logic              frm;
        logic [TIME_W-1:0] incr;
        logic [TIME_W-1:0] tol;
        logic [TIME_W-1:0] tat;
        frame_st_e         fst;
    } ctx_t;

    ctx_t              tbl [NCONN];
    ctx_t              cur;
    logic              conform;
    logic [TIME_W-1:0] tat_adv;
    frame_st_e         fst_nxt;
    verdict_e          fsm_vrd;
    verdict_e          vrd_now;
    logic              advance;
    logic              cfg_hits_cell;

    assign cur           = tbl[cell_conn];
    assign cfg_hits_cell = cfg_we && (cfg_conn == cell_conn);

    gcra_conform #(.TIME_W(TIME_W)) u_conform (
        .t_arr    (now),
        .tat      (cur.tat),
        .incr     (cur.incr),
        .tol      (cur.tol),
        .conform  (conform),
        .tat_next (tat_adv)
    );

    gcra_frame_fsm u_fsm (
        .cur_st      (cur.fst),
        .frame_en    (cur.frm),
        .discard_pol (cur.disc),
        .eof         (cell_eof),
        .conform     (conform),
        .nxt_st      (fst_nxt),
        .verdict     (fsm_vrd),
        .advance     (advance)
    );

    assign vrd_now = cur.en ? fsm_vrd : VRD_DROP;

    // Contract table: state register of every connection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCONN; i++) tbl[i] <= '0;
        end else begin
            if (cell_vld && cur.en && !cfg_hits_cell) begin
                tbl[cell_conn].fst <= fst_nxt;
                if (advance) tbl[cell_conn].tat <= tat_adv;
            end
            if (cfg_we) begin
                tbl[cfg_conn] <= '{en: 1'b1, disc: cfg_discard, frm: cfg_frame,
                                   incr: cfg_incr, tol: cfg_tol, tat: now,
                                   fst: FR_HEAD};
            end
        end
    end

    // Verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vrd_vld  <= 1'b0;
            vrd_code <= 2'b00;
            vrd_clp  <= 1'b0;
        end else begin
            vrd_vld  <= cell_vld;
            vrd_code <= vrd_now;
            vrd_clp  <= (vrd_now == VRD_TAG) ? 1'b1 : cell_clp;
        end
    end

    gcra_stats #(.CONN_W(CONN_W), .CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cell_vld),
        .inc_conn (cell_conn),
        .inc_kind (vrd_now),
        .clr      (cfg_we),
        .clr_conn (cfg_conn),
        .rd_conn  (stat_conn),
        .rd_pass  (stat_pass),
        .rd_tag   (stat_tag),
        .rd_drop  (stat_drop)
    );
endmodule

// File: rtl/gcra_policer_chk.sv
module gcra_policer_chk #(
    parameter int CONN_W = 10,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cell_vld,
    input logic              cell_clp,
    input logic              cfg_we,
    input logic [CONN_W-1:0] cfg_conn,
    input logic [CONN_W-1:0] stat_conn,
    input logic              vrd_vld,
    input logic [1:0]        vrd_code,
    input logic              vrd_clp,
    input logic [CNT_W-1:0]  stat_pass,
    input logic [CNT_W-1:0]  stat_tag,
    input logic [CNT_W-1:0]  stat_drop
);
    AST_VRD_FOLLOWS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld |=> vrd_vld);                                              // R2
    AST_VRD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_vld |=> !vrd_vld);                                            // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_vld |-> (vrd_code != 2'b11));                                   // R3
    AST_TAG_LOWPRI: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_vld && vrd_code == 2'b01) |-> vrd_clp);                        // R3
    AST_PASS_KEEPS_CLP: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_vld && vrd_code == 2'b00) |-> (vrd_clp == $past(cell_clp)));   // R3
    AST_CFG_CLEARS_STATS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && stat_conn == cfg_conn) |=>
        (!$stable(stat_conn) || (stat_pass == '0 && stat_tag == '0 && stat_drop == '0))); // R11
endmodule

bind gcra_policer gcra_policer_chk #(.CONN_W(CONN_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_vld  (cell_vld),
    .cell_clp  (cell_clp),
    .cfg_we    (cfg_we),
    .cfg_conn  (cfg_conn),
    .stat_conn (stat_conn),
    .vrd_vld   (vrd_vld),
    .vrd_code  (vrd_code),
    .vrd_clp   (vrd_clp),
    .stat_pass (stat_pass),
    .stat_tag  (stat_tag),
    .stat_drop (stat_drop)
);

// File: tb/gcra_policer_test.sv
module gcra_policer_test;
    localparam int CW = 2;
    localparam int TW = 8;
    localparam int NW = 4;
    localparam int NC = 4;
    localparam int SAT = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] now = '0;
    logic          cell_vld = 1'b0;
    logic [CW-1:0] cell_conn = '0;
    logic          cell_clp = 1'b0;
    logic          cell_eof = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_conn = '0;
    logic [TW-1:0] cfg_incr = '0;
    logic [TW-1:0] cfg_tol = '0;
    logic          cfg_discard = 1'b0;
    logic          cfg_frame = 1'b0;
    logic [CW-1:0] stat_conn = '0;
    logic          vrd_vld;
    logic [1:0]    vrd_code;
    logic          vrd_clp;
    logic [NW-1:0] stat_pass, stat_tag, stat_drop;

    gcra_policer #(.CONN_W(CW), .TIME_W(TW), .CNT_W(NW)) uut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int  checks = 0;
    int  errors = 0;
    int  abs_t  = 0;
    bit  done   = 0;

    // reference state, absolute (unwrapped) time
    int m_tat [NC];
    int m_incr[NC];
    int m_tol [NC];
    bit m_en  [NC];
    bit m_disc[NC];
    bit m_frm [NC];
    int m_fst [NC];          // 0 head, 1 good body, 2 penalised body
    int m_cnt [NC][3];       // pass, tag, drop

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_time();
        @(negedge clk);
        abs_t++;
        now = TW'(abs_t);
    endtask

    task automatic configure(input int c, input int incr, input int tol,
                             input bit disc, input bit frm);
        step_time();
        cfg_we = 1'b1; cfg_conn = CW'(c); cfg_incr = TW'(incr); cfg_tol = TW'(tol);
        cfg_discard = disc; cfg_frame = frm;
        m_en[c] = 1; m_tat[c] = abs_t; m_incr[c] = incr; m_tol[c] = tol;
        m_disc[c] = disc; m_frm[c] = frm; m_fst[c] = 0;
        for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
        @(posedge clk); #5;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step_time();
            @(posedge clk); #5;
            chk("R2 no verdict without cell", int'(vrd_vld), 0);
        end
    endtask

    task automatic send(input int c, input bit clp, input bit eof, input string req);
        int ev, pen, lead, base;
        bit conf;
        step_time();
        cell_vld = 1'b1; cell_conn = CW'(c); cell_clp = clp; cell_eof = eof;
        if (!m_en[c]) begin
            ev = 2;
        end else begin
            lead = m_tat[c] - abs_t;
            conf = (lead <= m_tol[c]);
            base = (abs_t > m_tat[c]) ? abs_t : m_tat[c];
            pen  = (m_disc[c] && !(m_frm[c] && eof)) ? 2 : 1;
            if (!m_frm[c] || m_fst[c] == 0) begin
                if (conf) begin ev = 0; m_tat[c] = base + m_incr[c]; end
                else ev = pen;
                if (m_frm[c] && !eof) m_fst[c] = conf ? 1 : 2;
            end else if (m_fst[c] == 1) begin
                ev = 0; m_tat[c] = base + m_incr[c];
                if (eof) m_fst[c] = 0;
            end else begin
                ev = pen;
                if (eof) m_fst[c] = 0;
            end
        end
        if (m_cnt[c][ev] < SAT) m_cnt[c][ev]++;
        @(posedge clk); #5;
        cell_vld = 1'b0;
        chk({req, " R2 valid"}, int'(vrd_vld), 1);
        chk({req, " R3 code"}, int'(vrd_code), ev);
        if (ev != 2) chk({req, " R3 clp"}, int'(vrd_clp), (ev == 1) ? 1 : int'(clp));
    endtask

    task automatic stats(input int c, input string req);
        step_time();
        stat_conn = CW'(c);
        #2;
        chk({req, " pass count"}, int'(stat_pass), m_cnt[c][0]);
        chk({req, " tag count"},  int'(stat_tag),  m_cnt[c][1]);
        chk({req, " drop count"}, int'(stat_drop), m_cnt[c][2]);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_en[c] = 0; m_fst[c] = 0; m_tat[c] = 0; m_incr[c] = 0; m_tol[c] = 0;
            m_disc[c] = 0; m_frm[c] = 0;
            for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
        end
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        chk("R1 vrd_vld in reset", int'(vrd_vld), 0);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) stats(c, "R1");
        idle(1);

        // R4: connection never configured
        send(3, 1'b0, 1'b0, "R4 unconfigured");
        send(3, 1'b1, 1'b1, "R4 unconfigured");
        stats(3, "R4 R11");

        // R5 R6 R7 R8: cell mode, tag policy, gap sweep across many wraps
        configure(0, 6, 3, 1'b0, 1'b0);
        for (int rep = 0; rep < 6; rep++)
            for (int g = 0; g < 10; g++) begin
                send(0, 1'((rep + g) % 2), 1'b0, "R5 R6 R7 R8 tag");
                idle(g);
            end
        stats(0, "R11 saturation");

        // R8: cell mode, discard policy
        configure(1, 4, 1, 1'b1, 1'b0);
        stats(1, "R11 R12 cleared");
        for (int rep = 0; rep < 3; rep++)
            for (int g = 0; g < 7; g++) begin
                send(1, 1'(g % 2), 1'(g % 3 == 0), "R5 R8 discard");
                idle(g);
            end
        stats(1, "R11");

        // R9 R10: frame mode, discard policy, then tag policy
        configure(2, 4, 2, 1'b1, 1'b1);
        configure(3, 3, 1, 1'b0, 1'b1);
        stats(3, "R11 R12 cleared");
        for (int c = 2; c < 4; c++)
            for (int len = 1; len <= 4; len++)
                for (int g = 0; g < 6; g++) begin
                    for (int i = 0; i < len; i++)
                        send(c, 1'((len + g + i) % 2), 1'(i == len - 1), "R9 R10 frame");
                    idle(g);
                end
        stats(2, "R10 R11");
        stats(3, "R10 R11");

        // R12: reconfiguration and interleaved independent connections
        configure(0, 3, 1, 1'b0, 1'b0);
        stats(0, "R11 R12 cleared");
        configure(1, 2, 0, 1'b1, 1'b0);
        for (int i = 0; i < 60; i++) begin
            send(i % 2, 1'(i % 3 == 0), 1'b0, "R12 interleave");
            if (i % 7 == 6) idle(i % 4);
        end
        stats(0, "R12 R11");
        stats(1, "R12 R11");

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule